// File: doc/BRIEF.md
# Vertical Sync Period Meter

This block measures how far apart successive vertical sync pulses are. It counts timebase ticks, each 8 us long, between one sync rising edge and the next. A prescaler inside the block makes the ticks by dividing the system clock. When the next edge arrives, the running count is copied to a read-only 14-bit output and counting starts again. The period of the incoming sync is therefore the latched value times 8 us.

The sync input is asynchronous to the system clock and is synchronised before edge detection. If the sync signal goes away, the running count stops at full scale and a sticky overflow flag is raised. The flag stays high until a one-cycle clear strobe arrives. The clear strobe acts on the flag only and never on the counters. A register wrapper can place the count and the flag on a bus.

Top module: `syncPeriodMeter`

## Requirements
- R1: After reset, `periodCount` is 0, `ovfFlag` is 0, and the running count is 0, so the first latch holds the ticks counted since reset.
- R2: The prescaler emits a one-clock tick every `TICK_DIV` clocks. The first tick comes on the `TICK_DIV`-th rising clock edge after reset. The default of 400 gives 8 us at 50 MHz. Each tick adds one to the running count.
- R3: On each rising edge of the synchronised sync, `periodCount` takes the running count and the running count restarts. A tick in that same cycle counts as the first tick of the new interval.
- R4: A steady sync whose period is exactly N tick periods produces `periodCount` = N. The period is therefore `periodCount` × 8 us.
- R5: With no sync edge, the running count stops at 16383. The next tick sets `ovfFlag`. The following sync edge latches 16383.
- R6: `ovfFlag` stays 1 across sync edges until `clrOvf` is high for a clock. It is not set again until a later interval overflows. A set and a clear in the same cycle leave it at 1.
- R7: `clrOvf` does not change `periodCount` or the running count.
- R8: `vsyncIn` passes through a two-stage synchroniser. `periodCount` changes on the third rising clock edge after `vsyncIn` rises. A level held high causes only one latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vsyncIn | input | 1 | Asynchronous vertical sync, active high |
| clrOvf | input | 1 | One-clock strobe that clears the overflow flag |
| periodCount | output | 14 | Latched tick count of the last complete sync interval |
| ovfFlag | output | 1 | Sticky flag: an interval ran past full scale |

## Verification
The assertions check on every cycle that the tick strobe and the edge strobe each last only one cycle. They also check that the latch copies the running count on an edge and holds it otherwise, that the count restarts, that the count saturates, and that the flag stays set until cleared and stays clear after a clear. The exact latched values can be shown only by the bench's scenarios, by comparing against a behavioural model. These scenarios cover the tick count from reset, the steady-period result, the synchroniser latency, a held-high sync, and the saturated value latched after an overflow that was cleared.

// File: rtl/spm_pkg.sv
package spm_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic tick;      // one timebase period elapsed
    logic syncEdge;  // rising edge of synchronised sync
    logic clrOvf;    // clear request for the overflow flag
  } spmStrobes_t;
endpackage

// File: rtl/spm_ctrl.sv
module spm_ctrl
  import spm_pkg::*;
#(
  parameter int TICK_DIV    = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        vsyncIn,
  input  logic        clrOvf,
  output spmStrobes_t strobes
);
  localparam int DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncPrev;
  logic [DIV_W-1:0]       divCount;

  // Synchroniser and edge-detect history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      syncPrev  <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], vsyncIn};
      syncPrev  <= syncChain[SYNC_STAGES-1];
    end
  end

  // Timebase prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCount <= '0;
    end else if (divCount == DIV_LAST) begin
      divCount <= '0;
    end else begin
      divCount <= divCount + 1'b1;
    end
  end

  always_comb begin
    strobes.tick     = (divCount == DIV_LAST);
    strobes.syncEdge = syncChain[SYNC_STAGES-1] & ~syncPrev;
    strobes.clrOvf   = clrOvf;
  end

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.syncEdge |=> !strobes.syncEdge); // R8

  generate
    if (TICK_DIV > 1) begin : gTickGap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rstN)
        strobes.tick |=> !strobes.tick); // R2
    end
  endgenerate
endmodule

// File: rtl/spm_datapath.sv
module spm_datapath
  import spm_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  spmStrobes_t      strobes,
  output logic [CNT_W-1:0] periodCount,
  output logic             ovfFlag
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] runCount;
  logic             pegged;   // interval already overflowed
  logic             atFull;
  logic             ovfHit;

  always_comb begin
    atFull = (runCount == FULL);
    ovfHit = strobes.tick && !strobes.syncEdge && atFull && !pegged;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCount    <= '0;
      pegged      <= 1'b0;
      periodCount <= '0;
    end else if (strobes.syncEdge) begin
      periodCount <= runCount;
      runCount    <= strobes.tick ? CNT_W'(1) : '0;
      pegged      <= 1'b0;
    end else if (strobes.tick) begin
      if (atFull) pegged   <= 1'b1;
      else        runCount <= runCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ovfFlag <= 1'b0;
    else if (ovfHit)         ovfFlag <= 1'b1;
    else if (strobes.clrOvf) ovfFlag <= 1'b0;
  end

  AST_LATCH_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.syncEdge |=> periodCount == $past(runCount)); // R3
  AST_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strobes.syncEdge |=> runCount <= CNT_W'(1)); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.syncEdge |=> $stable(periodCount)); // R7
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && !strobes.syncEdge && atFull) |=> runCount == FULL); // R5
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(runCount) == FULL); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !strobes.clrOvf) |=> ovfFlag); // R6
  AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrOvf && !ovfHit) |=> !ovfFlag); // R6
endmodule

// File: rtl/syncPeriodMeter.sv
module syncPeriodMeter
  import spm_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int TICK_DIV    = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             vsyncIn,
  input  logic             clrOvf,
  output logic [CNT_W-1:0] periodCount,
  output logic             ovfFlag
);
  spmStrobes_t strobes;

  spm_ctrl #(
    .TICK_DIV   (TICK_DIV),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .vsyncIn(vsyncIn),
    .clrOvf (clrOvf),
    .strobes(strobes)
  );

  spm_datapath #(
    .CNT_W(CNT_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .periodCount(periodCount),
    .ovfFlag    (ovfFlag)
  );
endmodule

// File: tb/syncPeriodMeter_test.sv
module syncPeriodMeter_test;
  localparam int DIV  = 4;
  localparam int FULL = 16383;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        vsyncIn = 1'b0;
  logic        clrOvf = 1'b0;
  logic [13:0] periodCount;
  logic        ovfFlag;

  int errs = 0;
  int checks = 0;
  bit cmpOn = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  int mS1 = 0, mS2 = 0, mPrev = 0, mDiv = 0, mCnt = 0, mLat = 0;
  int mOvf = 0, mPeg = 0;

  syncPeriodMeter #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .vsyncIn(vsyncIn), .clrOvf(clrOvf),
    .periodCount(periodCount), .ovfFlag(ovfFlag)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    vsyncIn = 1'b1;
    waitCyc(hi);
    vsyncIn = 1'b0;
    waitCyc(lo);
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mPrev = 0; mDiv = 0; mCnt = 0; mLat = 0; mOvf = 0; mPeg = 0;
    end else begin
      int edgeNow, tickNow, setNow;
      edgeNow = (mS2 == 1 && mPrev == 0);
      tickNow = (mDiv == DIV - 1);
      setNow  = tickNow && !edgeNow && mCnt == FULL && !mPeg;
      mPrev = mS2; mS2 = mS1; mS1 = vsyncIn;
      mDiv = tickNow ? 0 : mDiv + 1;
      if (edgeNow) begin
        mLat = mCnt; mCnt = tickNow ? 1 : 0; mPeg = 0;
      end else if (tickNow) begin
        if (mCnt == FULL) mPeg = 1; else mCnt = mCnt + 1;
      end
      if (setNow) mOvf = 1;
      else if (clrOvf) mOvf = 0;
    end
  end

  // compare against the model every clock
  always @(negedge clk) begin
    if (rstN && cmpOn) begin
      check(periodCount == mLat, "R3 periodCount", periodCount, mLat);
      check(ovfFlag == mOvf, "R6 ovfFlag", ovfFlag, mOvf);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int old;
    waitCyc(3);
    rstN = 1'b1;
    // R1: reset state
    check(periodCount == 0, "R1 periodCount", periodCount, 0);
    check(ovfFlag == 0, "R1 ovfFlag", ovfFlag, 0);
    cmpOn = 1'b1;

    // R2: ticks since reset land in the first latch (42 clocks / 4)
    waitCyc(40);
    vsyncIn = 1'b1;
    waitCyc(3);
    check(periodCount == 10, "R2 first latch", periodCount, 10);
    waitCyc(7);
    vsyncIn = 1'b0;
    waitCyc(390);

    // R4: steady period of 100 ticks
    for (int i = 0; i < 4; i++) pulse(10, 390);
    check(periodCount == 100, "R4 steady period", periodCount, 100);

    // R3: irregular spacing and short pulses
    pulse(1, 37); pulse(2, 5); pulse(3, 123); pulse(1, 2); pulse(2, 250); pulse(1, 61);
    waitCyc(500);

    // R8: synchroniser latency and held level
    old = periodCount;
    vsyncIn = 1'b1;
    waitCyc(2);
    check(periodCount == old, "R8 no change before third edge", periodCount, old);
    waitCyc(1);
    check(periodCount == mLat && mLat != old, "R8 change on third edge", periodCount, mLat);
    old = periodCount;
    waitCyc(300);
    check(periodCount == old, "R8 held high no relatch", periodCount, old);
    vsyncIn = 1'b0;

    // R5: overflow with no sync
    waitCyc(FULL * DIV + 100);
    check(ovfFlag == 1, "R5 overflow set", ovfFlag, 1);
    old = periodCount;
    clrOvf = 1'b1;
    waitCyc(1);
    clrOvf = 1'b0;
    waitCyc(50);
    check(ovfFlag == 0, "R6 cleared stays clear", ovfFlag, 0);
    check(periodCount == old, "R7 clear keeps latch", periodCount, old);
    pulse(2, 20);
    check(periodCount == FULL, "R5 R7 saturated value latched", periodCount, FULL);
    check(ovfFlag == 0, "R6 no reset after clear", ovfFlag, 0);

    // R6: sticky across edges
    waitCyc(FULL * DIV + 100);
    check(ovfFlag == 1, "R5 second overflow", ovfFlag, 1);
    pulse(2, 100); pulse(2, 100);
    check(ovfFlag == 1, "R6 sticky across edges", ovfFlag, 1);
    clrOvf = 1'b1;
    waitCyc(1);
    clrOvf = 1'b0;
    waitCyc(5);
    check(ovfFlag == 0, "R6 clear strobe", ovfFlag, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule